// File: doc/BRIEF.md
# AHB-Lite to Avalon-MM Single-Transfer Bridge

This block sits between an AHB-Lite bus master and a memory-mapped slave that speaks Avalon-MM, with both sides on one clock. The AHB side is a slave front end. For every valid single transfer it builds a command word holding the direction, the byte address, the write data and the byte enables, and puts that word into a small command queue. The Avalon side is a master sequencer. It takes words out of the queue one at a time and runs one single-word Avalon-MM transaction for each.

Writes are posted. The AHB master sees a write finish as soon as its command is queued, however long the Avalon slave stalls. Reads hold the AHB data phase until every earlier queued command has run, the read has been accepted, and the slave's delayed response has arrived. The read data then goes straight to HRDATA in the cycle in which HREADY goes high. Because the queue keeps its order, a read always sees the effect of every write issued before it.

Top module: `ahb_avmm_bridge`

## Requirements
- R1: After reset, hready_out is 1, avm_read and avm_write are 0, and hresp is 0.
- R2: An address phase with hsel=1, hready_in=1 and htrans equal to NONSEQ (2'b10) or SEQ (2'b11) yields exactly one Avalon command. IDLE (2'b00), BUSY (2'b01) or hsel=0 yields none.
- R3: A write data phase ends with hready_out high in its first cycle whenever the queue has a free slot, even while avm_waitrequest is held high.
- R4: When the queue already holds FIFO_DEPTH commands (default 4), a write data phase holds hready_out low until a slot frees. No command is lost.
- R5: Avalon commands come out in AHB order. avm_address equals haddr, and avm_writedata equals hwdata from the write's data phase. The next command is taken only after the current one is accepted (avm_waitrequest low).
- R6: avm_byteenable (bit n = byte lane n) follows hsize and haddr[1:0]:
  - size 0 gives 1<<haddr[1:0];
  - size 1 gives 4'b0011 or 4'b1100 by haddr[1];
  - size 2 gives 4'b1111.
- R7: While avm_read or avm_write is high with avm_waitrequest high, address, data, byte enables and strobes stay unchanged in the next cycle. avm_read and avm_write are never high together.
- R8: A read data phase keeps hready_out low until avm_readdatavalid. It ends in that same cycle with hrdata equal to avm_readdata, which reflects every earlier write.
- R9: hresp is 0 (OKAY) in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | AHB slave select |
| haddr | input | ADDR_W | AHB byte address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB direction, 1 = write |
| hsize | input | 3 | AHB transfer size |
| hwdata | input | DATA_W | AHB write data (data phase) |
| hready_in | input | 1 | AHB bus ready seen by this slave |
| hready_out | output | 1 | Ready driven by this slave |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | DATA_W | AHB read data |
| avm_address | output | ADDR_W | Avalon byte address |
| avm_read | output | 1 | Avalon read strobe |
| avm_write | output | 1 | Avalon write strobe |
| avm_writedata | output | DATA_W | Avalon write data |
| avm_byteenable | output | DATA_W/8 | Avalon byte lane enables |
| avm_waitrequest | input | 1 | Avalon slave stall |
| avm_readdata | input | DATA_W | Avalon read data |
| avm_readdatavalid | input | 1 | Avalon read data strobe |

## Verification
Some rules are checked on every cycle by the assertions:
- the Avalon command is held stable while stalled;
- the queue neither overflows nor underflows;
- a command is taken only once the previous one was accepted;
- a read response arrives only while a read is waiting.

Other behaviour only the bench scenarios can show, comparing against a behavioural shadow memory and an ordered list of expected commands:
- that posted writes finish at once under a stalled slave;
- that a full queue stalls the next write;
- that IDLE and BUSY transfers produce no command;
- that byte enables match each size and offset;
- that reads return data reflecting all earlier writes under random stalls and response delays.

// File: rtl/ahb2avm_pkg.sv
package ahb2avm_pkg;
    // Avalon sequencer states
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_XFER   = 2'd1,
        ENG_RDWAIT = 2'd2
    } eng_state_e;
endpackage

// File: rtl/ahb_slave_front.sv
module ahb_slave_front #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [AW-1:0]     haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DW-1:0]     hwdata,
    input  logic              hready_in,
    output logic              hready_out,
    output logic              hresp,
    output logic [DW-1:0]     hrdata,
    input  logic              q_full,
    output logic              q_push,
    output logic              cmd_write,
    output logic [AW-1:0]     cmd_addr,
    output logic [DW-1:0]     cmd_wdata,
    output logic [DW/8-1:0]   cmd_be,
    input  logic              rsp_valid,
    input  logic [DW-1:0]     rsp_data
);
    localparam int NB   = DW / 8;
    localparam int OFFW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic          act;
        logic          wr;
        logic [AW-1:0] addr;
        logic [2:0]    size;
        logic          rd_sent;
    } dphase_t;

    dphase_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        q_push     = 1'b0;
        hready_out = 1'b1;
        if (st_q.act) begin
            if (st_q.rd_sent) begin
                hready_out = rsp_valid;
            end else if (q_full) begin
                hready_out = 1'b0;
            end else begin
                q_push = 1'b1;
                if (!st_q.wr) begin
                    hready_out   = 1'b0;
                    st_d.rd_sent = 1'b1;
                end
            end
        end
        if (hready_in) begin
            st_d.act     = hsel && ((htrans == 2'b10) || (htrans == 2'b11));
            st_d.wr      = hwrite;
            st_d.addr    = haddr;
            st_d.size    = hsize;
            st_d.rd_sent = 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cmd_be[i] = ((OFFW'(i) ^ st_q.addr[OFFW-1:0]) >> st_q.size) == '0;
        end
    end

    assign cmd_write = st_q.wr;
    assign cmd_addr  = st_q.addr;
    assign cmd_wdata = st_q.wr ? hwdata : '0;
    assign hrdata    = rsp_data;
    assign hresp     = 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (st_q.act && st_q.rd_sent));
endmodule

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = (st_q.wp == PW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop)  st_d.rp = (st_q.rp == PW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= wdata;
    end

    assign rdata = mem_q[st_q.rp];
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/avm_master_seq.sv
module avm_master_seq
    import ahb2avm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_empty,
    output logic              q_pop,
    input  logic              q_write,
    input  logic [AW-1:0]     q_addr,
    input  logic [DW-1:0]     q_wdata,
    input  logic [DW/8-1:0]   q_be,
    output logic [AW-1:0]     avm_address,
    output logic              avm_read,
    output logic              avm_write,
    output logic [DW-1:0]     avm_writedata,
    output logic [DW/8-1:0]   avm_byteenable,
    input  logic              avm_waitrequest,
    input  logic              avm_readdatavalid
);
    typedef struct packed {
        eng_state_e        state;
        logic              wr;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     data;
        logic [DW/8-1:0]   be;
    } eng_t;

    eng_t st_d, st_q;
    logic take;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q.state)
            ENG_IDLE:   take = !q_empty;
            ENG_XFER: begin
                if (!avm_waitrequest) begin
                    if (!st_q.wr)     st_d.state = ENG_RDWAIT;
                    else if (q_empty) st_d.state = ENG_IDLE;
                    else              take = 1'b1;
                end
            end
            ENG_RDWAIT: if (avm_readdatavalid) st_d.state = ENG_IDLE;
            default:    st_d.state = ENG_IDLE;
        endcase
        if (take) begin
            st_d.state = ENG_XFER;
            st_d.wr    = q_write;
            st_d.addr  = q_addr;
            st_d.data  = q_wdata;
            st_d.be    = q_be;
        end
        q_pop = take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avm_read       = (st_q.state == ENG_XFER) && !st_q.wr;
    assign avm_write      = (st_q.state == ENG_XFER) && st_q.wr;
    assign avm_address    = st_q.addr;
    assign avm_writedata  = st_q.data;
    assign avm_byteenable = st_q.be;

    // R7
    hold_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((avm_read || avm_write) && avm_waitrequest) |=>
        ($stable(avm_address) && $stable(avm_writedata) && $stable(avm_byteenable)
         && $stable(avm_read) && $stable(avm_write)));
    // R5
    pop_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> (!avm_waitrequest || !(avm_read || avm_write)));
endmodule

// File: rtl/ahb_avmm_bridge.sv
module ahb_avmm_bridge #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsel,
    input  logic [ADDR_W-1:0]   haddr,
    input  logic [1:0]          htrans,
    input  logic                hwrite,
    input  logic [2:0]          hsize,
    input  logic [DATA_W-1:0]   hwdata,
    input  logic                hready_in,
    output logic                hready_out,
    output logic                hresp,
    output logic [DATA_W-1:0]   hrdata,
    output logic [ADDR_W-1:0]   avm_address,
    output logic                avm_read,
    output logic                avm_write,
    output logic [DATA_W-1:0]   avm_writedata,
    output logic [DATA_W/8-1:0] avm_byteenable,
    input  logic                avm_waitrequest,
    input  logic [DATA_W-1:0]   avm_readdata,
    input  logic                avm_readdatavalid
);
    localparam int NB    = DATA_W / 8;
    localparam int CMD_W = 1 + ADDR_W + DATA_W + NB;

    logic              q_full, q_empty, q_push, q_pop;
    logic              c_wr, h_wr;
    logic [ADDR_W-1:0] c_addr, h_addr;
    logic [DATA_W-1:0] c_data, h_data;
    logic [NB-1:0]     c_be, h_be;
    logic [CMD_W-1:0]  head;

    ahb_slave_front #(.AW(ADDR_W), .DW(DATA_W)) front_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready_in(hready_in),
        .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata),
        .q_full(q_full), .q_push(q_push), .cmd_write(c_wr), .cmd_addr(c_addr),
        .cmd_wdata(c_data), .cmd_be(c_be),
        .rsp_valid(avm_readdatavalid), .rsp_data(avm_readdata)
    );

    cmd_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(q_push), .wdata({c_wr, c_addr, c_data, c_be}),
        .pop(q_pop), .rdata(head), .full(q_full), .empty(q_empty)
    );

    assign {h_wr, h_addr, h_data, h_be} = head;

    avm_master_seq #(.AW(ADDR_W), .DW(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .q_empty(q_empty), .q_pop(q_pop),
        .q_write(h_wr), .q_addr(h_addr), .q_wdata(h_data), .q_be(h_be),
        .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
        .avm_writedata(avm_writedata), .avm_byteenable(avm_byteenable),
        .avm_waitrequest(avm_waitrequest), .avm_readdatavalid(avm_readdatavalid)
    );
endmodule

// File: tb/ahb_avmm_bridge_tb_top.sv
module ahb_avmm_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd2;
    logic [31:0] hwdata = '0;
    logic        hready_in, hready_out, hresp;
    logic [31:0] hrdata;
    logic [31:0] avm_address, avm_writedata;
    logic        avm_read, avm_write;
    logic [3:0]  avm_byteenable;
    logic        avm_waitrequest = 1'b0;
    logic [31:0] avm_readdata = '0;
    logic        avm_readdatavalid = 1'b0;

    always #4 clk = ~clk;
    assign hready_in = hready_out;

    ahb_avmm_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready_in(hready_in),
        .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata),
        .avm_address(avm_address), .avm_read(avm_read), .avm_write(avm_write),
        .avm_writedata(avm_writedata), .avm_byteenable(avm_byteenable),
        .avm_waitrequest(avm_waitrequest), .avm_readdata(avm_readdata),
        .avm_readdatavalid(avm_readdatavalid)
    );

    int errors = 0, checks = 0, acc_cnt = 0, issued = 0, wmode = 0, rd_cnt = 0;
    bit done = 0;

    typedef struct { bit w; logic [31:0] a; logic [3:0] be; logic [31:0] d; } cmd_t;
    cmd_t expq[$];
    typedef struct { bit v; bit w; logic [31:0] a; logic [3:0] be; logic [31:0] d; } xf_t;
    xf_t prev = '{default: '0};

    logic [31:0] shadow [int];
    logic [31:0] slvmem [int];
    logic [31:0] rd_addr;
    bit          hold_q = 0;
    logic [31:0] h_a, h_d;
    logic [3:0]  h_be;
    logic        h_r, h_w;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] be_exp(input logic [2:0] sz, input logic [31:0] a);
        case (sz)
            3'd0:    return 4'b0001 << a[1:0];
            3'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                          input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] sh_get(input int k);
        return shadow.exists(k) ? shadow[k] : 32'h0;
    endfunction

    function automatic logic [31:0] sl_get(input int k);
        return slvmem.exists(k) ? slvmem[k] : 32'h0;
    endfunction

    // Avalon slave model, command and per-clock checks
    always @(negedge clk) begin
        if (rst_n) begin
            cmd_t e;
            bit wq;
            chk(hresp == 1'b0, "R9", "hresp", {31'b0, hresp}, 32'h0);
            chk(!(avm_read && avm_write), "R7", "both strobes", {30'b0, avm_read, avm_write}, 32'h0);
            if (hold_q)
                chk(avm_address == h_a && avm_writedata == h_d && avm_byteenable == h_be &&
                    avm_read == h_r && avm_write == h_w, "R7", "held command changed",
                    avm_address, h_a);
            avm_readdatavalid = 1'b0;
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    avm_readdatavalid = 1'b1;
                    avm_readdata = sl_get(int'(rd_addr >> 2));
                end
            end
            case (wmode)
                0:       wq = 1'b0;
                1:       wq = ($urandom % 3) == 0;
                default: wq = 1'b1;
            endcase
            avm_waitrequest = wq;
            hold_q = (avm_read || avm_write) && wq;
            h_a = avm_address; h_d = avm_writedata; h_be = avm_byteenable;
            h_r = avm_read; h_w = avm_write;
            if ((avm_read || avm_write) && !wq) begin
                acc_cnt++;
                if (expq.size() == 0) begin
                    chk(1'b0, "R2", "unexpected command", avm_address, 32'h0);
                end else begin
                    e = expq.pop_front();
                    chk(avm_write == e.w, "R5", "direction order", {31'b0, avm_write}, {31'b0, e.w});
                    chk(avm_address == e.a, "R5", "address order", avm_address, e.a);
                    chk(avm_byteenable == e.be, "R6", "byteenable", {28'b0, avm_byteenable}, {28'b0, e.be});
                    if (e.w) chk(avm_writedata == e.d, "R5", "writedata", avm_writedata, e.d);
                end
                if (avm_write)
                    slvmem[int'(avm_address >> 2)] =
                        merge(sl_get(int'(avm_address >> 2)), avm_writedata, avm_byteenable);
                else begin
                    rd_addr = avm_address;
                    rd_cnt = 1 + int'($urandom % 3);
                end
            end
        end
    end

    // One AHB address phase, overlapped with the previous data phase.
    // stalls returns the wait cycles of the previous data phase.
    task automatic issue(input bit sel, input logic [1:0] tr, input bit w,
                         input logic [31:0] a, input logic [2:0] sz,
                         input logic [31:0] d, output int stalls);
        @(negedge clk);
        hsel = sel; htrans = tr; hwrite = w; haddr = a; hsize = sz;
        if (prev.v && prev.w) hwdata = prev.d;
        #1;
        stalls = 0;
        while (!hready_out) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        if (prev.v && !prev.w) begin
            chk(avm_readdatavalid == 1'b1, "R8", "read done without response",
                {31'b0, avm_readdatavalid}, 32'h1);
            chk(hrdata == sh_get(int'(prev.a >> 2)), "R8", "read data", hrdata,
                sh_get(int'(prev.a >> 2)));
        end
        if (prev.v && prev.w)
            shadow[int'(prev.a >> 2)] = merge(sh_get(int'(prev.a >> 2)), prev.d, prev.be);
        prev = '{v: 1'b0, w: 1'b0, a: '0, be: '0, d: '0};
        if (sel && tr[1]) begin
            issued++;
            prev = '{v: 1'b1, w: w, a: a, be: be_exp(sz, a), d: d};
            expq.push_back('{w: w, a: a, be: be_exp(sz, a), d: w ? d : 32'h0});
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && (expq.size() != 0 || rd_cnt != 0); i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int st, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1: reset state
        chk(hready_out == 1'b1, "R1", "hready_out", {31'b0, hready_out}, 32'h1);
        chk(!avm_read && !avm_write, "R1", "strobes", {30'b0, avm_read, avm_write}, 32'h0);
        chk(hresp == 1'b0, "R1", "hresp", {31'b0, hresp}, 32'h0);

        // R5 R8: word writes then reads, no stalls
        wmode = 0;
        issue(1, 2'b10, 1, 32'h10, 3'd2, 32'hA5A5_0001, st);
        issue(1, 2'b10, 1, 32'h14, 3'd2, 32'h1234_5678, st);
        issue(1, 2'b10, 0, 32'h10, 3'd2, 0, st);
        issue(1, 2'b11, 0, 32'h14, 3'd2, 0, st);   // SEQ accepted as single (R2)
        issue(0, 2'b00, 0, 0, 3'd2, 0, st);
        drain();

        // R6: byte and halfword lanes, then a word read
        issue(1, 2'b10, 1, 32'h21, 3'd0, 32'h0000_BB00, st);
        issue(1, 2'b10, 1, 32'h23, 3'd0, 32'hCC00_0000, st);
        issue(1, 2'b10, 1, 32'h24, 3'd1, 32'h0000_DDEE, st);
        issue(1, 2'b10, 1, 32'h26, 3'd1, 32'h7788_0000, st);
        issue(1, 2'b10, 0, 32'h20, 3'd2, 0, st);
        issue(1, 2'b10, 0, 32'h24, 3'd2, 0, st);
        issue(0, 2'b00, 0, 0, 3'd2, 0, st);
        drain();

        // R3 R4: slave stalled, posted writes then a full queue
        wmode = 2;
        issue(1, 2'b10, 1, 32'h40, 3'd2, 32'h0000_0040, st);
        for (int k = 1; k < 6; k++) begin
            issue(1, 2'b10, 1, 32'h40 + 32'(k * 4), 3'd2, 32'h0000_0040 + 32'(k), st);
            chk(st == 0, "R3", "posted write stalled", 32'(st), 32'h0);
        end
        fork
            begin repeat (12) @(negedge clk); wmode = 0; end
        join_none
        issue(1, 2'b10, 0, 32'h54, 3'd2, 0, st);
        chk(st > 0, "R4", "write into full queue not stalled", 32'(st), 32'h1);
        issue(0, 2'b00, 0, 0, 3'd2, 0, st);
        drain();

        // R2: IDLE, BUSY and unselected NONSEQ make no command
        base = acc_cnt;
        issue(1, 2'b00, 1, 32'h80, 3'd2, 32'hDEAD_0001, st);
        issue(1, 2'b01, 1, 32'h84, 3'd2, 32'hDEAD_0002, st);
        issue(0, 2'b10, 1, 32'h88, 3'd2, 32'hDEAD_0003, st);
        issue(0, 2'b00, 0, 0, 3'd2, 0, st);
        repeat (6) @(negedge clk);
        chk(acc_cnt == base, "R2", "command from idle/busy/unselected", 32'(acc_cnt), 32'(base));
        chk(!avm_read && !avm_write, "R2", "strobes after idle", {30'b0, avm_read, avm_write}, 32'h0);

        // R5 R6 R8: random mix under random stalls and response delays
        wmode = 1;
        for (int n = 0; n < 60; n++) begin
            logic [2:0]  sz = 3'($urandom % 3);
            logic [31:0] a  = 32'h100 + 32'(($urandom % 8) * 4);
            a[1:0] = 2'($urandom % 4) & ~2'((1 << sz) - 1);
            issue(1, 2'b10, 1'($urandom % 2), a, sz, $urandom, st);
        end
        issue(0, 2'b00, 0, 0, 3'd2, 0, st);
        wmode = 0;
        drain();

        // R2: every valid transfer produced exactly one command
        chk(expq.size() == 0, "R2", "commands missing", 32'(expq.size()), 32'h0);
        chk(acc_cnt == issued, "R2", "command count", 32'(acc_cnt), 32'(issued));
        finish_run();
    end
endmodule